// File: doc/BRIEF.md
# Lane Swizzle Permute Unit

This unit moves one data word per lane across a group of lanes (32 by default) in a single registered step. For each destination lane it computes a source-lane index from a mode code and a small set of parameters. The modes are a four-lane permute, a per-bit rewrite of the lane id, a broadcast of one lane inside each power-of-two group, an exchange of neighbouring power-of-two groups, and a reversal of lane order inside each group. A crossbar then gathers the selected words and writes them into an output register.

A per-lane active mask decides two things. A destination lane that is inactive is not written, so it keeps the value already in the output register. A destination lane whose source lane is inactive receives zero. A broadcast request whose index does not fit inside its group raises an error flag for that result and passes every lane's own word through unchanged. A new request can be presented on every clock cycle, and each result appears one cycle after its request.

Top module: `lane_swizzle_unit`

## Requirements
- R1: While `rst` is high at a clock edge, the next state has `out_valid` = 0, `out_err` = 0 and every lane of `out_data` = 0.
- R2: `out_valid` is high exactly in the cycle after a cycle with `in_valid` high, and requests on back-to-back cycles each give a result.
- R3: With `in_mode` = 0 (quad permute), lane `i` reads lane `4*(i/4) + q`, where `q` is the 2-bit field `quad_sel[2*(i%4)+1 : 2*(i%4)]`.
- R4: With `in_mode` = 1 (bit rewrite), source-id bit `b` is built from lane-id bit `b` using the 2-bit code `bit_ops[2b+1:2b]`: 0 gives 0, 1 gives 1, 2 keeps the bit, 3 inverts it.
- R5: With `in_mode` = 2 (broadcast) and group size `G = 2**grp_log` with `grp_log` from 1 to 5, every lane of a group reads the lane at offset `bc_index` inside that group.
- R6: In broadcast mode, if `grp_log` is 0 or above 5, or `bc_index >= G`, then `out_err` is 1 for that result and every lane reads its own word. `out_err` is 0 for every other request.
- R7: With `in_mode` = 3 (swap) and `grp_log` from 0 to 4, lane `i` reads the matching lane of the neighbouring group of size `2**grp_log` (lane id bit `grp_log` inverted). Larger `grp_log` values give identity.
- R8: With `in_mode` = 4 (reverse) and `grp_log` from 1 to 5, lane order is reversed inside each group of `2**grp_log` lanes. Other `grp_log` values give identity.
- R9: An active destination lane whose source lane has its `in_active` bit clear receives zero.
- R10: A destination lane whose `in_active` bit is clear keeps its previous `out_data` value.
- R11: Mode codes 5, 6 and 7 give identity, so each active lane receives its own word.
- R12: While `in_valid` is low, `out_data` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| in_data | input | LANES*DW | Lane words, lane `i` at bits `[i*DW +: DW]` |
| in_active | input | LANES | Per-lane active mask |
| in_mode | input | 3 | 0 quad, 1 bit rewrite, 2 broadcast, 3 swap, 4 reverse, others identity |
| quad_sel | input | 8 | Four 2-bit source positions for quad mode |
| bit_ops | input | 2*IDW | Per-id-bit rewrite codes |
| grp_log | input | 3 | log2 of the group size for broadcast, swap and reverse |
| bc_index | input | IDW | Broadcast lane offset inside a group |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| out_data | output | LANES*DW | Permuted lane words |
| out_err | output | 1 | Broadcast index or group size rejected |

## Verification
The two mask rules are hard to reach from the ports because they overlap. A lane can be an active destination that reads an inactive source, and it can also be an inactive destination whose held value must survive. Seeing both needs a known register state first. The stimulus therefore loads an identity result with all lanes active, then sends a reverse and a broadcast request with sparse masks, so that zeroed lanes, held lanes and normally gathered lanes all appear in the same vector. Rejected broadcasts are driven both with an index equal to the group size and with out-of-range group sizes.

// File: rtl/swz_pkg.sv
package swz_pkg;
  typedef enum logic [2:0] {
    MODE_QUAD  = 3'd0,
    MODE_BITS  = 3'd1,
    MODE_BCAST = 3'd2,
    MODE_SWAP  = 3'd3,
    MODE_REV   = 3'd4
  } swz_mode_e;

  typedef enum logic [1:0] {
    BIT_ZERO = 2'd0,
    BIT_ONE  = 2'd1,
    BIT_KEEP = 2'd2,
    BIT_FLIP = 2'd3
  } bit_op_e;
endpackage

// File: rtl/swz_index_gen.sv
module swz_index_gen #(
  parameter int LANES = 32,
  parameter int IDW   = $clog2(LANES)
) (
  input  logic [2:0]           mode,
  input  logic [7:0]           quad_sel,
  input  logic [2*IDW-1:0]     bit_ops,
  input  logic [2:0]           grp_log,
  input  logic [IDW-1:0]       bc_index,
  output logic [LANES*IDW-1:0] src_idx,
  output logic                 bcast_err
);
  import swz_pkg::*;

  localparam int GW = IDW + 1;

  logic [GW-1:0]  grp_full;
  logic [IDW-1:0] gmask;
  logic           bad_bcast;

  always_comb begin
    grp_full  = (GW'(1) << grp_log) - GW'(1);
    gmask     = grp_full[IDW-1:0];
    bad_bcast = (grp_log == 3'd0) || (32'(grp_log) > IDW) || (bc_index > gmask);
    bcast_err = (mode == MODE_BCAST) && bad_bcast;
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    localparam logic [IDW-1:0] ME = IDW'(g);
    logic [IDW-1:0] src;

    always_comb begin
      src = ME;
      case (mode)
        MODE_QUAD: src = {ME[IDW-1:2], quad_sel[{ME[1:0], 1'b0} +: 2]};
        MODE_BITS: begin
          for (int b = 0; b < IDW; b++) begin
            case (bit_ops[2*b +: 2])
              BIT_ZERO: src[b] = 1'b0;
              BIT_ONE:  src[b] = 1'b1;
              BIT_KEEP: src[b] = ME[b];
              default:  src[b] = ~ME[b];
            endcase
          end
        end
        MODE_BCAST: if (!bad_bcast) src = (ME & ~gmask) | (bc_index & gmask);
        MODE_SWAP:  if (32'(grp_log) < IDW) src = ME ^ (IDW'(1) << grp_log);
        MODE_REV:   if (32'(grp_log) <= IDW) src = ME ^ gmask;
        default:    src = ME;
      endcase
    end

    assign src_idx[g*IDW +: IDW] = src;
  end
endmodule

// File: rtl/swz_crossbar.sv
module swz_crossbar #(
  parameter int LANES = 32,
  parameter int DW    = 32,
  parameter int IDW   = $clog2(LANES)
) (
  input  logic [LANES*DW-1:0]  in_data,
  input  logic [LANES-1:0]     in_active,
  input  logic [LANES*IDW-1:0] src_idx,
  output logic [LANES*DW-1:0]  gathered
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [IDW-1:0] s;
    assign s = src_idx[g*IDW +: IDW];
    assign gathered[g*DW +: DW] = in_active[s] ? in_data[s*DW +: DW] : '0;
  end
endmodule

// File: rtl/lane_swizzle_unit.sv
module lane_swizzle_unit #(
  parameter int LANES = 32,
  parameter int DW    = 32,
  parameter int IDW   = $clog2(LANES)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  input  logic [LANES*DW-1:0] in_data,
  input  logic [LANES-1:0]    in_active,
  input  logic [2:0]          in_mode,
  input  logic [7:0]          quad_sel,
  input  logic [2*IDW-1:0]    bit_ops,
  input  logic [2:0]          grp_log,
  input  logic [IDW-1:0]      bc_index,
  output logic                out_valid,
  output logic [LANES*DW-1:0] out_data,
  output logic                out_err
);
  import swz_pkg::*;

  logic [LANES*IDW-1:0] src_idx;
  logic [LANES*DW-1:0]  gathered;
  logic                 bcast_err;

  swz_index_gen #(.LANES(LANES), .IDW(IDW)) u_index (
    .mode(in_mode), .quad_sel(quad_sel), .bit_ops(bit_ops),
    .grp_log(grp_log), .bc_index(bc_index),
    .src_idx(src_idx), .bcast_err(bcast_err)
  );

  swz_crossbar #(.LANES(LANES), .DW(DW), .IDW(IDW)) u_xbar (
    .in_data(in_data), .in_active(in_active),
    .src_idx(src_idx), .gathered(gathered)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_err   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      out_err   <= in_valid & bcast_err;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_out
    always_ff @(posedge clk) begin
      if (rst)
        out_data[g*DW +: DW] <= '0;
      else if (in_valid && in_active[g])
        out_data[g*DW +: DW] <= gathered[g*DW +: DW];
    end
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk) rst |=> (!out_valid && !out_err && out_data == '0));

  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst) in_valid |=> out_valid);

  // R2
  valid_idle_chk: assert property (@(posedge clk) disable iff (rst) !in_valid |=> !out_valid);

  // R6
  err_bcast_only_chk: assert property (@(posedge clk) disable iff (rst)
    !(in_valid && in_mode == MODE_BCAST) |=> !out_err);

  // R12
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst) !in_valid |=> $stable(out_data));

  // R10
  lane0_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !in_active[0]) |=> $stable(out_data[DW-1:0]));
endmodule

// File: tb/tb_lane_swizzle_unit.sv
`timescale 1ns/1ps
module tb_lane_swizzle_unit;
  localparam int LANES = 32;
  localparam int DW    = 32;
  localparam int IDW   = 5;

  logic                clk = 1'b0;
  logic                rst;
  logic                in_valid;
  logic [LANES*DW-1:0] in_data;
  logic [LANES-1:0]    in_active;
  logic [2:0]          in_mode;
  logic [7:0]          quad_sel;
  logic [2*IDW-1:0]    bit_ops;
  logic [2:0]          grp_log;
  logic [IDW-1:0]      bc_index;
  logic                out_valid;
  logic [LANES*DW-1:0] out_data;
  logic                out_err;

  int checks = 0;
  int errors = 0;
  logic [DW-1:0] model [LANES];

  always #2 clk = ~clk;

  lane_swizzle_unit #(.LANES(LANES), .DW(DW), .IDW(IDW)) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .in_active(in_active), .in_mode(in_mode), .quad_sel(quad_sel),
    .bit_ops(bit_ops), .grp_log(grp_log), .bc_index(bc_index),
    .out_valid(out_valid), .out_data(out_data), .out_err(out_err)
  );

  function automatic logic [DW-1:0] word_of(int tag, int lane);
    return 32'hA500_0000 | (tag << 8) | lane;
  endfunction

  // Reference source lane from the requirement text; sets err for rejected broadcast.
  function automatic int ref_src(int lane, int mode, output bit err);
    int gs, base, off, s;
    err = 0;
    s = lane;
    gs = 1 << grp_log;
    base = (lane / gs) * gs;
    off = lane % gs;
    case (mode)
      0: s = (lane / 4) * 4 + ((quad_sel >> (2 * (lane % 4))) & 3);
      1: begin
        s = 0;
        for (int b = 0; b < IDW; b++) begin
          int code, bitv;
          code = (bit_ops >> (2 * b)) & 3;
          bitv = (lane >> b) & 1;
          if (code == 1) s += (1 << b);
          else if (code == 2) s += bitv << b;
          else if (code == 3) s += (1 - bitv) << b;
        end
      end
      2: begin
        if (grp_log == 0 || grp_log > 5 || bc_index >= gs) err = 1;
        else s = base + bc_index;
      end
      3: if (grp_log <= 4) s = (((lane / gs) ^ 1) * gs) + off;
      4: if (grp_log >= 1 && grp_log <= 5) s = base + (gs - 1 - off);
      default: s = lane;
    endcase
    return s;
  endfunction

  task automatic fill_data(int tag);
    for (int i = 0; i < LANES; i++) in_data[i*DW +: DW] = word_of(tag, i);
  endtask

  // Drive one request, wait for its result, and compare it with the reference.
  task automatic run_req(string req, int mode, int tag, logic [LANES-1:0] act);
    bit err, exp_err;
    int bad_lane;
    logic [DW-1:0] nxt [LANES];
    exp_err = 0;
    @(negedge clk);
    fill_data(tag);
    in_active = act;
    in_mode = 3'(mode);
    in_valid = 1'b1;
    for (int i = 0; i < LANES; i++) begin
      int s;
      s = ref_src(i, mode, err);
      if (err) exp_err = 1;
      nxt[i] = model[i];
      if (act[i]) nxt[i] = act[s] ? word_of(tag, s) : '0;
    end
    @(negedge clk);
    in_valid = 1'b0;
    for (int i = 0; i < LANES; i++) model[i] = nxt[i];
    bad_lane = -1;
    for (int i = LANES - 1; i >= 0; i--)
      if (out_data[i*DW +: DW] !== model[i]) bad_lane = i;
    checks++;
    if (bad_lane >= 0) begin
      errors++;
      $display("FAIL %s lane %0d: got %h expected %h", req, bad_lane,
               out_data[bad_lane*DW +: DW], model[bad_lane]);
    end
    checks++;
    if (out_valid !== 1'b1 || out_err !== exp_err) begin
      errors++;
      $display("FAIL %s flags: got valid=%b err=%b expected valid=1 err=%b",
               req, out_valid, out_err, exp_err);
    end
  endtask

  task automatic test_reset();
    rst = 1'b1; in_valid = 1'b0; in_active = '0; in_mode = '0;
    quad_sel = '0; bit_ops = '0; grp_log = '0; bc_index = '0; in_data = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < LANES; i++) model[i] = '0;
    checks++;
    if (out_valid !== 1'b0 || out_err !== 1'b0 || out_data !== '0) begin
      errors++;
      $display("FAIL R1 reset: got valid=%b err=%b data!=0 expected all zero", out_valid, out_err);
    end
  endtask

  task automatic test_quad();
    quad_sel = 8'b00_01_10_11;
    run_req("R3 quad reverse", 0, 1, '1);
    quad_sel = 8'b10_10_10_10;
    run_req("R3 quad replicate", 0, 2, '1);
  endtask

  task automatic test_bits();
    bit_ops = {2'd3, 2'd2, 2'd1, 2'd0, 2'd3};
    run_req("R4 bit rewrite mix", 1, 3, '1);
    bit_ops = {5{2'd2}};
    run_req("R4 bit keep all", 1, 4, '1);
  endtask

  task automatic test_bcast();
    grp_log = 3'd2; bc_index = 5'd3;
    run_req("R5 broadcast g4", 2, 5, '1);
    grp_log = 3'd5; bc_index = 5'd17;
    run_req("R5 broadcast g32", 2, 6, '1);
    grp_log = 3'd3; bc_index = 5'd8;
    run_req("R6 broadcast index=size", 2, 7, '1);
    grp_log = 3'd6; bc_index = 5'd0;
    run_req("R6 broadcast bad size", 2, 8, '1);
    grp_log = 3'd0; bc_index = 5'd0;
    run_req("R6 broadcast size1", 2, 9, '1);
  endtask

  task automatic test_swap_rev();
    grp_log = 3'd0;
    run_req("R7 swap 1", 3, 10, '1);
    grp_log = 3'd3;
    run_req("R7 swap 8", 3, 11, '1);
    grp_log = 3'd5;
    run_req("R7 swap too wide", 3, 12, '1);
    grp_log = 3'd5;
    run_req("R8 reverse 32", 4, 13, '1);
    grp_log = 3'd1;
    run_req("R8 reverse 2", 4, 14, '1);
  endtask

  task automatic test_masks();
    run_req("R11 identity load", 7, 15, '1);
    grp_log = 3'd5;
    run_req("R9 R10 reverse sparse", 4, 16, 32'h0F0F_33CC);
    grp_log = 3'd2; bc_index = 5'd1;
    run_req("R9 R10 broadcast sparse", 2, 17, 32'hAAAA_5555);
  endtask

  task automatic test_idle_and_stream();
    logic [LANES*DW-1:0] snap;
    snap = out_data;
    @(negedge clk);
    fill_data(40); in_mode = 3'd4; in_active = '1;
    repeat (3) @(negedge clk);
    checks++;
    if (out_data !== snap || out_valid !== 1'b0) begin
      errors++;
      $display("FAIL R12 idle: data changed or valid=%b expected stable, valid=0", out_valid);
    end
    grp_log = 3'd1;
    run_req("R2 stream first", 3, 20, '1);
    // back-to-back: keep in_valid high across two requests
    @(negedge clk);
    fill_data(21); in_mode = 3'd5; in_active = '1; in_valid = 1'b1;
    @(negedge clk);
    fill_data(22);
    checks++;
    if (out_valid !== 1'b1 || out_data[5*DW +: DW] !== word_of(21, 5)) begin
      errors++;
      $display("FAIL R2 back-to-back first: valid=%b lane5=%h expected 1 %h",
               out_valid, out_data[5*DW +: DW], word_of(21, 5));
    end
    @(negedge clk);
    in_valid = 1'b0;
    checks++;
    if (out_valid !== 1'b1 || out_data[5*DW +: DW] !== word_of(22, 5)) begin
      errors++;
      $display("FAIL R2 back-to-back second: valid=%b lane5=%h expected 1 %h",
               out_valid, out_data[5*DW +: DW], word_of(22, 5));
    end
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0) begin
      errors++;
      $display("FAIL R2 valid drop: got %b expected 0", out_valid);
    end
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    test_reset();
    test_quad();
    test_bits();
    test_bcast();
    test_swap_rev();
    test_masks();
    test_idle_and_stream();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule